// File: doc/BRIEF.md
# Stereo Crossfeed FIR Convolution Engine

This block turns one stereo sample pair per frame into a crossfed stereo pair. Each output channel is the sum of two convolutions. One is a direct path: the channel's own history through coefficient set A. The other is a cross path: the opposite channel's history through coefficient set B. The same two sets serve both outputs, so the structure is symmetric. A single multiply-accumulate unit runs all four convolutions one after another, well inside a 512-clock frame. The block then applies a selectable right shift to the sum, saturates the result to 16 bits and registers it.

A 3-bit selection code picks what the engine applies. Codes 0 to 5 pick fixed test patterns. Code 6 picks the downloadable sets held in an internal coefficient RAM. Code 7 passes the inputs through untouched. A change of selection never switches abruptly: the output gain ramps down to zero, the new selection is swapped in, and the gain ramps back up.

Top module: `xfeed_fir_engine`

## Requirements
- R1: After reset, out_l and out_r are 0 and out_valid is 0. Pass-through (code 7) is the active selection, at full gain, and the sample history is all zero.
- R2: The rising edge that samples frame_strobe high while the engine is idle stores in_l and in_r as the newest history samples. out_valid is then high for exactly one cycle, 4*TAPS+1 cycles after that edge. out_l and out_r change only when out_valid rises.
- R3: A frame_strobe that arrives while a frame is still being computed, up to and including the cycle before out_valid rises, is ignored. No sample enters the history.
- R4: With x[t] the sample t frames back (t = 0 is newest) and coefficients as signed Q15, sum_l = Σ A[t]*L[t] + Σ B[t]*R[t] and sum_r = Σ A[t]*R[t] + Σ B[t]*L[t], for t from 0 to TAPS-1.
- R5: Each sum is shifted arithmetically right (floor) by 15 plus shift_code bits, so shift_code 0, 1, 2 and 3 add 0, 1, 2 and 3 bits of attenuation.
- R6: The shifted result saturates to the range -32768 to 32767 and never wraps.
- R7: cw_en writes cw_data into coefficient RAM word cw_addr on a clock edge. Under code 6, set A is read from words 0 to TAPS-1 and set B from words TAPS to 2*TAPS-1, both indexed by tap.
- R8: Under code k (0 to 5), set A is 16384 at tap k and 0 elsewhere. Set B is -8192 at tap k+2 and 0 elsewhere.
- R9: Under code 7, the outputs equal the current frame's inputs scaled only by the fade gain. shift_code has no effect in this mode.
- R10: The output is floor(pre*g / 2^FADE_LOG2), where g starts at G = 2^FADE_LOG2. The selection code is compared with the active selection at each result. If they differ while no fade is running, the following results use gains G-1 down to 1 with the old selection. Next comes a result at gain 0 with the selection code in force at that point, then gains 1 up to G with the new selection. Selection changes during a fade are seen only after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | One-cycle pulse that starts a frame |
| in_l | input | 16 | Left input sample, signed |
| in_r | input | 16 | Right input sample, signed |
| sel_code | input | 3 | Selection: 0-5 test patterns, 6 RAM sets, 7 pass-through |
| shift_code | input | 2 | Extra right shift of the sum, 0 to 3 bits |
| cw_en | input | 1 | Coefficient RAM write enable |
| cw_addr | input | 8 | Coefficient RAM word address |
| cw_data | input | 16 | Coefficient value, signed Q15 |
| out_l | output | 16 | Left result, signed |
| out_r | output | 16 | Right result, signed |
| out_valid | output | 1 | One-cycle pulse marking new results |

## Verification
The fade swap and the result latch share one cycle. In the cycle that registers a result at gain 1, the engine also drops the gain to zero and installs the new selection. A wrong ordering would let the new coefficients leak into the last old-selection output, or hold the old ones for one frame too many. The vector table changes the selection several times, including into and out of pass-through. A reference model that follows the gain schedule of R10 frame by frame judges every output of each ramp. A second overlap is a strobe that lands mid-computation. It is judged by the outputs of the following frames, whose history must not contain the injected sample.

// File: rtl/xfeed_fir_engine.sv
`timescale 1ns/1ps
module xfeed_fir_engine #(
  parameter int TAPS      = 125,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int ACC_W     = 40,
  parameter int FADE_LOG2 = 8,
  parameter int CADDR_W   = $clog2(2*TAPS)
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_strobe,
  input  logic signed [DW-1:0]      in_l,
  input  logic signed [DW-1:0]      in_r,
  input  logic [2:0]                sel_code,
  input  logic [1:0]                shift_code,
  input  logic                      cw_en,
  input  logic [CADDR_W-1:0]        cw_addr,
  input  logic signed [CW-1:0]      cw_data,
  output logic signed [DW-1:0]      out_l,
  output logic signed [DW-1:0]      out_r,
  output logic                      out_valid
);

  localparam int TW    = $clog2(TAPS);
  localparam int GW    = FADE_LOG2 + 1;
  localparam int PW    = DW + CW;
  localparam int CFRAC = CW - 1;
  localparam logic [GW-1:0] G_FULL = {1'b1, {FADE_LOG2{1'b0}}};
  localparam logic signed [CW-1:0] P_DIR = CW'(2**(CW-2));
  localparam logic signed [CW-1:0] P_CRS = CW'(-(2**(CW-3)));
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2**(DW-1) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;
  localparam logic [2:0] SEL_RAM = 3'd6;
  localparam logic [2:0] SEL_THRU = 3'd7;

  typedef enum logic [1:0] {F_IDLE, F_DOWN, F_UP} fade_t;

  logic signed [DW-1:0] hist_l [TAPS];
  logic signed [DW-1:0] hist_r [TAPS];
  logic signed [CW-1:0] cram [2*TAPS];

  logic                    busy, done;
  logic [TW-1:0]           tap;
  logic [1:0]              pass;
  logic signed [ACC_W-1:0] acc_l, acc_r;
  logic [2:0]              act_sel;
  logic [GW-1:0]           gain;
  fade_t                   fst;

  wire take  = frame_strobe && !busy && !done;
  wire set_b = pass[0];
  wire to_r  = pass[1];
  wire use_r = pass[0] ^ pass[1];

  logic signed [DW-1:0]    sample;
  logic [CADDR_W-1:0]      ram_idx;
  logic signed [CW-1:0]    preset_c, coef;
  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] prod_x;

  assign sample   = use_r ? hist_r[tap] : hist_l[tap];
  assign ram_idx  = CADDR_W'(tap) + (set_b ? CADDR_W'(TAPS) : '0);
  assign preset_c = !set_b ? ((int'(tap) == int'(act_sel))     ? P_DIR : '0)
                           : ((int'(tap) == int'(act_sel) + 2) ? P_CRS : '0);
  assign coef     = (act_sel == SEL_RAM) ? cram[ram_idx] : preset_c;
  assign prod     = sample * coef;
  assign prod_x   = ACC_W'(prod);

  always_ff @(posedge clk) begin
    if (cw_en && cw_addr < CADDR_W'(2*TAPS))
      cram[cw_addr] <= cw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) begin
        hist_l[i] <= '0;
        hist_r[i] <= '0;
      end
    end else if (take) begin
      hist_l[0] <= in_l;
      hist_r[0] <= in_r;
      for (int i = 1; i < TAPS; i++) begin
        hist_l[i] <= hist_l[i-1];
        hist_r[i] <= hist_r[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      tap   <= '0;
      pass  <= '0;
      acc_l <= '0;
      acc_r <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        busy  <= 1'b1;
        tap   <= '0;
        pass  <= '0;
        acc_l <= '0;
        acc_r <= '0;
      end else if (busy) begin
        if (to_r) acc_r <= acc_r + prod_x;
        else      acc_l <= acc_l + prod_x;
        if (tap == TW'(TAPS-1)) begin
          tap  <= '0;
          pass <= pass + 2'd1;
          if (pass == 2'd3) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          tap <= tap + 1'b1;
        end
      end
    end
  end

  function automatic logic signed [DW-1:0] sat(input logic signed [ACC_W-1:0] v);
    if (v > SAT_HI)      return SAT_HI[DW-1:0];
    else if (v < SAT_LO) return SAT_LO[DW-1:0];
    else                 return v[DW-1:0];
  endfunction

  logic signed [ACC_W-1:0] sh_l, sh_r;
  logic signed [DW-1:0]    pre_l, pre_r;
  logic signed [DW+GW:0]   fl, fr;
  logic signed [DW-1:0]    fade_l, fade_r;

  assign sh_l   = acc_l >>> (CFRAC + int'(shift_code));
  assign sh_r   = acc_r >>> (CFRAC + int'(shift_code));
  assign pre_l  = (act_sel == SEL_THRU) ? hist_l[0] : sat(sh_l);
  assign pre_r  = (act_sel == SEL_THRU) ? hist_r[0] : sat(sh_r);
  assign fl     = pre_l * $signed({1'b0, gain});
  assign fr     = pre_r * $signed({1'b0, gain});
  assign fade_l = DW'(fl >>> FADE_LOG2);
  assign fade_r = DW'(fr >>> FADE_LOG2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_l     <= '0;
      out_r     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= done;
      if (done) begin
        out_l <= fade_l;
        out_r <= fade_r;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst     <= F_IDLE;
      gain    <= G_FULL;
      act_sel <= SEL_THRU;
    end else if (done) begin
      case (fst)
        F_IDLE: if (sel_code != act_sel) begin
          fst  <= F_DOWN;
          gain <= gain - 1'b1;
        end
        F_DOWN: if (gain == GW'(1)) begin
          gain    <= '0;
          act_sel <= sel_code;
          fst     <= F_UP;
        end else begin
          gain <= gain - 1'b1;
        end
        F_UP: begin
          gain <= gain + 1'b1;
          if (gain == G_FULL - 1'b1) fst <= F_IDLE;
        end
        default: fst <= F_IDLE;
      endcase
    end
  end

endmodule

module xfeed_fir_chk #(
  parameter int TAPS = 125,
  parameter int DW   = 16,
  parameter int GW   = 9
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_strobe,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic [GW-1:0]        gain_i,
  input logic [2:0]           act_sel_i
);
  localparam int LAT = 4*TAPS + 1;
  logic pend;
  int   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      cnt  <= 0;
    end else if (!pend) begin
      if (frame_strobe) begin
        pend <= 1'b1;
        cnt  <= 1;
      end
    end else begin
      cnt <= cnt + 1;
      if (cnt == LAT) pend <= 1'b0;
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(pend) && $past(cnt) == LAT));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_l) && $stable(out_r)));

  // R10
  swap_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_sel_i) |-> (gain_i == '0));

  // R10
  gain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_i) |-> out_valid);
endmodule

bind xfeed_fir_engine xfeed_fir_chk #(.TAPS(TAPS), .DW(DW), .GW(FADE_LOG2+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .out_valid(out_valid),
  .out_l(out_l), .out_r(out_r), .gain_i(gain), .act_sel_i(act_sel)
);

// File: tb/tb_xfeed_fir_engine.sv
`timescale 1ns/1ps
module tb_xfeed_fir_engine;
  localparam int TAPS = 125;
  localparam int FL   = 2;
  localparam int G    = 1 << FL;
  localparam int LAT  = 4*TAPS + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_strobe = 1'b0;
  logic signed [15:0] in_l = '0, in_r = '0;
  logic [2:0] sel_code = 3'd7;
  logic [1:0] shift_code = '0;
  logic cw_en = 1'b0;
  logic [7:0] cw_addr = '0;
  logic signed [15:0] cw_data = '0;
  logic signed [15:0] out_l, out_r;
  logic out_valid;

  always #10 clk = ~clk;

  xfeed_fir_engine #(.TAPS(TAPS), .FADE_LOG2(FL)) dut (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .in_l(in_l), .in_r(in_r),
    .sel_code(sel_code), .shift_code(shift_code), .cw_en(cw_en), .cw_addr(cw_addr),
    .cw_data(cw_data), .out_l(out_l), .out_r(out_r), .out_valid(out_valid)
  );

  int nvec = 0, nfail = 0;
  longint hl [TAPS], hr [TAPS];
  longint ram_m [2*TAPS];
  int mact = 7, mg = G, mst = 0;

  localparam logic [36:0] VEC [24] = '{
    {3'd7, 2'd3,  16'sd1000,   -16'sd2000},
    {3'd7, 2'd0, -16'sd32768,   16'sd32767},
    {3'd0, 2'd0,  16'sd12000,   16'sd5000},
    {3'd0, 2'd1, -16'sd7000,    16'sd3000},
    {3'd0, 2'd0,  16'sd30000,  -16'sd30000},
    {3'd0, 2'd2, -16'sd1,       16'sd1},
    {3'd0, 2'd0,  16'sd20000,   16'sd10000},
    {3'd0, 2'd0, -16'sd15000,   16'sd25000},
    {3'd0, 2'd3,  16'sd32767,  -16'sd32768},
    {3'd0, 2'd0,  16'sd4444,   -16'sd4444},
    {3'd0, 2'd0, -16'sd123,     16'sd9876},
    {3'd0, 2'd1,  16'sd16000,  -16'sd16000},
    {3'd3, 2'd0,  16'sd8000,   -16'sd8000},
    {3'd3, 2'd0, -16'sd30001,   16'sd2},
    {3'd3, 2'd1,  16'sd777,     16'sd31000},
    {3'd3, 2'd0,  16'sd25000,  -16'sd12345},
    {3'd3, 2'd2, -16'sd32768,  -16'sd32768},
    {3'd3, 2'd0,  16'sd11111,   16'sd22222},
    {3'd3, 2'd3,  16'sd32767,   16'sd32767},
    {3'd3, 2'd0, -16'sd5,      -16'sd6000},
    {3'd3, 2'd0,  16'sd19000,   16'sd300},
    {3'd5, 2'd0, -16'sd9000,    16'sd9000},
    {3'd5, 2'd1,  16'sd100,     16'sd200},
    {3'd5, 2'd0,  16'sd3000,   -16'sd29000}
  };

  task automatic check(input string req, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint mcoef(input int sel, input int setb, input int t);
    if (sel == 6) return ram_m[setb*TAPS + t];
    if (setb == 0) return (t == sel) ? 64'sd16384 : 64'sd0;
    return (t == sel + 2) ? -64'sd8192 : 64'sd0;
  endfunction

  function automatic longint msat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_frame(input longint l, input longint r, input int sh, input int seln,
                             output longint el, output longint er);
    longint al = 0, ar = 0, pl, pr;
    for (int t = TAPS-1; t > 0; t--) begin hl[t] = hl[t-1]; hr[t] = hr[t-1]; end
    hl[0] = l; hr[0] = r;
    for (int t = 0; t < TAPS; t++) begin
      al += hl[t]*mcoef(mact, 0, t) + hr[t]*mcoef(mact, 1, t);
      ar += hr[t]*mcoef(mact, 0, t) + hl[t]*mcoef(mact, 1, t);
    end
    if (mact == 7) begin pl = l; pr = r; end
    else begin pl = msat(al >>> (15 + sh)); pr = msat(ar >>> (15 + sh)); end
    el = (pl * mg) >>> FL;
    er = (pr * mg) >>> FL;
    case (mst)
      0: if (seln != mact) begin mst = 1; mg = mg - 1; end
      1: if (mg == 1) begin mg = 0; mact = seln; mst = 2; end else mg = mg - 1;
      default: begin mg = mg + 1; if (mg == G) mst = 0; end
    endcase
  endtask

  task automatic write_ram(input int addr, input int val);
    @(negedge clk);
    cw_en = 1'b1; cw_addr = 8'(addr); cw_data = 16'(val);
    ram_m[addr] = longint'(signed'(16'(val)));
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic run_frame(input logic signed [15:0] l, input logic signed [15:0] r,
                           input int sel, input int sh, input bit inject, input string tag);
    longint el, er;
    int cnt = 0;
    string lab = tag;
    if (tag == "") begin
      if (mst != 0 || sel != mact) lab = "R10";
      else if (mact == 7) lab = "R9";
      else if (sh != 0) lab = "R5";
      else lab = "R4+R8";
    end
    @(negedge clk);
    in_l = l; in_r = r; sel_code = 3'(sel); shift_code = 2'(sh); frame_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_strobe = 1'b0;
    while (!out_valid && cnt < 2000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (inject && cnt == 100) begin
        frame_strobe = 1'b1; in_l = 16'sd31111; in_r = -16'sd31111;
      end else begin
        frame_strobe = 1'b0;
      end
      if (inject && cnt == LAT - 1) frame_strobe = 1'b1;
    end
    frame_strobe = 1'b0;
    model_frame(longint'(l), longint'(r), sh, sel, el, er);
    check("R2", cnt, LAT);
    check(lab, out_l, el);
    check(lab, out_r, er);
    repeat (8) @(posedge clk);
  endtask

  initial begin
    for (int t = 0; t < TAPS; t++) begin hl[t] = 0; hr[t] = 0; end
    for (int a = 0; a < 2*TAPS; a++) ram_m[a] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", out_l, 0);
    check("R1", out_r, 0);
    check("R1", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_valid, 0);

    // R7 coefficient RAM load, set A at words 0.., set B at TAPS..
    for (int a = 0; a < 2*TAPS; a++) write_ram(a, 0);
    write_ram(0, 20000);
    write_ram(3, -12000);
    write_ram(TAPS + 1, 15000);
    write_ram(TAPS + TAPS - 1, 7000);

    // vector table: R4 cross structure, R5 shift, R8 presets, R9 bypass, R10 fades
    for (int i = 0; i < 24; i++) begin
      logic [36:0] v = VEC[i];
      run_frame(v[31:16], v[15:0], int'(v[36:34]), int'(v[33:32]), 1'b0, "");
    end

    // R7 downloaded sets, fading in
    for (int i = 0; i < 12; i++)
      run_frame(16'(1000*i - 5000), 16'(7000 - 900*i), 6, i % 2, 1'b0,
                (mst != 0 || mact != 6) ? "R10" : "R7");
    // R3 strobes during computation must leave the history untouched
    run_frame(16'sd2500, -16'sd1500, 6, 0, 1'b1, "R3");
    for (int i = 0; i < 4; i++) run_frame(16'(300*i), -16'sd700, 6, 0, 1'b0, "R3");

    // R6 saturation both ways, R5 shift on a large sum
    write_ram(0, 32767);
    write_ram(TAPS, 32767);
    for (int i = 0; i < 3; i++) run_frame(16'sd32767, 16'sd32767, 6, 0, 1'b0, "R6");
    check("R6", out_l, 32767);
    run_frame(16'sd32767, 16'sd32767, 6, 3, 1'b0, "R5");
    for (int i = 0; i < 3; i++) run_frame(-16'sd32768, -16'sd32768, 6, 0, 1'b0, "R6");
    check("R6", out_r, -32768);

    // R9 back to pass-through, extremes
    for (int i = 0; i < 10; i++)
      run_frame((i % 2) ? -16'sd32768 : 16'sd32767, 16'(i*1234), 7, 3, 1'b0, "");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired, R2 frame sequencing hung");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule